// File: doc/BRIEF.md
# On-chip trace capture buffer

The block is a trace sink that keeps its data on chip. Trace words arrive on a handshaked input bus (valid, ready, data and a source ID). They are written into an internal circular RAM whose size is set by a parameter. A debugger works the block through a small register port with APB-style setup and access phases. It sets capture enable and the storage mode, places the write and read pointers, and drains the RAM word by word through a data register. Because both pointers are visible, software can read the buffer in place without copying it.

Two storage modes are available. In formatted mode, a source-ID word is written ahead of the data whenever the source changes. Bypass mode is meant for a system with a single trace source: raw words are stored with no ID words, which saves RAM. A trigger input from a cross-trigger controller arms a programmable countdown of further writes. When the countdown ends, capture stops and a one-cycle trigger output is raised.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset every register reads zero (CTRL, STATUS, WPTR, RPTR, TRIGCNT) and `tr_ready` is high.
- R2: Each stored word goes to the RAM entry at the write pointer, and the write pointer then advances by one. It wraps from DEPTH-1 to 0, and a write to entry DEPTH-1 sets the sticky full flag.
- R3: The register index is `paddr`. 0 is CTRL (bit0 capture enable, bit1 bypass). 1 is STATUS (bit0 full, bit1 triggered, bit2 stopped), and any write to it clears all three bits. 2 is WPTR, 3 is RPTR, 4 is DATA (read only) and 5 is TRIGCNT. Read data is registered in the setup phase and is valid during the access phase.
- R4: A read of DATA returns the RAM word at the read pointer, and the read pointer then advances by one, wrapping at DEPTH.
- R5: While capture enable is 0, `tr_ready` stays high and offered words are dropped: the write pointer does not move.
- R6: In bypass mode (CTRL bit1 = 1), each accepted word is stored once, unchanged, and `tr_ready` stays high.
- R7: In formatted mode (CTRL bit1 = 0), an ID word is stored before the data when the source ID differs from the previous one, or for the first word after any CTRL write. The ID word has bit DATA_W-1 set, the ID in bits ID_W-1:0, and zero elsewhere. `tr_ready` is low for the one cycle in which the held data word is written.
- R8: A trigger pulse while capture is enabled and not yet triggered sets the triggered flag and loads TRIGCNT. Exactly TRIGCNT further words are then stored (ID words count). After that the stopped flag is set and later words are dropped while `tr_ready` stays high.
- R9: `trig_out` is a single-cycle pulse, raised once when capture stops because the trigger count has run out.
- R10: Writes to WPTR and RPTR load the pointers, and later stores and reads start from the loaded positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_valid | input | 1 | Trace word offered |
| tr_ready | output | 1 | Block accepts the offered word |
| tr_data | input | DATA_W | Trace word |
| tr_id | input | ID_W | Source ID of the trace word |
| trig_in | input | 1 | Trigger from cross-trigger controller |
| trig_out | output | 1 | Pulse when capture stops after trigger |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register write when high |
| paddr | input | 3 | Register index |
| pwdata | input | DATA_W | Register write data |
| prdata | output | DATA_W | Register read data |

## Verification
The bench builds the block with DATA_W = 16, ADDR_W = 3 (eight entries), ID_W = 4 and CNT_W = 8. With only eight entries, a short run reaches the pointer wrap and the full flag, and a read can be started at the last entry so that it crosses into entry zero. The 16-bit word gives ID words the fixed value 16'h8000 plus the ID. The trigger countdown is checked with counts of three and zero, and the number of entries stored and the final pointer are computed arithmetically in the bench.

// File: rtl/trcb_pkg.sv
package trcb_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_STATUS = 3'd1,
    REG_WPTR   = 3'd2,
    REG_RPTR   = 3'd3,
    REG_DATA   = 3'd4,
    REG_TRIG   = 3'd5
  } reg_idx_e;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_BYPASS_BIT = 1;
endpackage

// File: rtl/trcb_ram.sv
module trcb_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trcb_capture.sv
module trcb_capture #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int ID_W   = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic [DATA_W-1:0] tr_data,
  input  logic [ID_W-1:0]   tr_id,
  input  logic              trig_in,
  output logic              trig_out,
  input  logic              cfg_en,
  input  logic              cfg_bypass,
  input  logic [CNT_W-1:0]  cfg_trigcnt,
  input  logic              wptr_ld,
  input  logic [ADDR_W-1:0] wptr_val,
  input  logic              stat_clr,
  input  logic              fmt_restart,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wptr,
  output logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              triggered,
  output logic              stopped
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              hold_vld;
  logic [DATA_W-1:0] hold_data;
  logic              id_known;
  logic [ID_W-1:0]   last_id;
  logic [CNT_W-1:0]  rem;
  logic              count_out;
  logic              can_wr;
  logic              accept;
  logic              need_id;
  logic              wr_is_id;
  logic [DATA_W-1:0] id_word;

  assign tr_ready  = ~hold_vld;
  assign accept    = tr_valid & tr_ready;
  assign count_out = triggered & (rem == '0);
  assign can_wr    = cfg_en & ~stopped & ~count_out;
  assign need_id   = ~cfg_bypass & (~id_known | (tr_id != last_id));

  always_comb begin
    id_word = '0;
    id_word[DATA_W-1] = 1'b1;
    id_word[ID_W-1:0] = tr_id;
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_data  = tr_data;
    wr_is_id = 1'b0;
    if (hold_vld) begin
      wr_en   = can_wr;
      wr_data = hold_data;
    end else if (accept && can_wr) begin
      wr_en = 1'b1;
      if (need_id) begin
        wr_data  = id_word;
        wr_is_id = 1'b1;
      end
    end
  end

  // formatter state
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
      id_known  <= 1'b0;
      last_id   <= '0;
    end else if (fmt_restart) begin
      hold_vld <= 1'b0;
      id_known <= 1'b0;
    end else if (hold_vld) begin
      hold_vld <= 1'b0;
    end else if (wr_is_id) begin
      hold_vld  <= 1'b1;
      hold_data <= tr_data;
      id_known  <= 1'b1;
      last_id   <= tr_id;
    end
  end

  // write pointer and full flag
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      full <= 1'b0;
    end else begin
      if (wptr_ld)    wptr <= wptr_val;
      else if (wr_en) wptr <= wptr + 1'b1;
      if (stat_clr)                    full <= 1'b0;
      else if (wr_en && wptr == LAST)  full <= 1'b1;
    end
  end

  // trigger countdown
  always_ff @(posedge clk) begin
    if (rst) begin
      triggered <= 1'b0;
      stopped   <= 1'b0;
      rem       <= '0;
      trig_out  <= 1'b0;
    end else if (stat_clr) begin
      triggered <= 1'b0;
      stopped   <= 1'b0;
      rem       <= '0;
      trig_out  <= 1'b0;
    end else begin
      trig_out <= count_out & ~stopped;
      if (count_out) stopped <= 1'b1;
      if (trig_in && cfg_en && !triggered) begin
        triggered <= 1'b1;
        rem       <= cfg_trigcnt;
      end else if (triggered && wr_en) begin
        rem <= rem - 1'b1;
      end
    end
  end

  a_r2_wrap_full: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wptr_ld && !stat_clr && wptr == LAST) |=> (wptr == '0 && full));

  a_r8_no_write_stopped: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !wr_en);

  a_r7_id_then_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_is_id && !fmt_restart) |=> !tr_ready);

  a_r9_pulse_then_stopped: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> (!trig_out && (stopped || $past(stat_clr))));
endmodule

// File: rtl/trcb_regs.sv
module trcb_regs
  import trcb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [2:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              st_full,
  input  logic              st_trig,
  input  logic              st_stop,
  input  logic [ADDR_W-1:0] wptr,
  input  logic [DATA_W-1:0] ram_q,
  output logic              ram_re,
  output logic [ADDR_W-1:0] rptr,
  output logic              cfg_en,
  output logic              cfg_bypass,
  output logic [CNT_W-1:0]  cfg_trigcnt,
  output logic              wptr_ld,
  output logic [ADDR_W-1:0] wptr_val,
  output logic              stat_clr,
  output logic              fmt_restart
);
  logic              setup_ph;
  logic              acc_wr;
  logic              acc_rd;
  logic              data_sel_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_hold;

  assign setup_ph    = psel & ~penable;
  assign acc_wr      = psel & penable & pwrite;
  assign acc_rd      = psel & penable & ~pwrite;
  assign ram_re      = setup_ph & ~pwrite & (paddr == REG_DATA);
  assign wptr_ld     = acc_wr & (paddr == REG_WPTR);
  assign wptr_val    = pwdata[ADDR_W-1:0];
  assign stat_clr    = acc_wr & (paddr == REG_STATUS);
  assign fmt_restart = acc_wr & (paddr == REG_CTRL);

  always_comb begin
    rd_mux = '0;
    case (paddr)
      REG_CTRL: begin
        rd_mux[CTRL_EN_BIT]     = cfg_en;
        rd_mux[CTRL_BYPASS_BIT] = cfg_bypass;
      end
      REG_STATUS: rd_mux[2:0]       = {st_stop, st_trig, st_full};
      REG_WPTR:   rd_mux[ADDR_W-1:0] = wptr;
      REG_RPTR:   rd_mux[ADDR_W-1:0] = rptr;
      REG_TRIG:   rd_mux[CNT_W-1:0]  = cfg_trigcnt;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en      <= 1'b0;
      cfg_bypass  <= 1'b0;
      cfg_trigcnt <= '0;
      rptr        <= '0;
      rd_hold     <= '0;
      data_sel_q  <= 1'b0;
    end else begin
      if (setup_ph && !pwrite) begin
        rd_hold    <= rd_mux;
        data_sel_q <= (paddr == REG_DATA);
      end
      if (acc_wr && paddr == REG_CTRL) begin
        cfg_en     <= pwdata[CTRL_EN_BIT];
        cfg_bypass <= pwdata[CTRL_BYPASS_BIT];
      end
      if (acc_wr && paddr == REG_TRIG) cfg_trigcnt <= pwdata[CNT_W-1:0];
      if (acc_wr && paddr == REG_RPTR)       rptr <= pwdata[ADDR_W-1:0];
      else if (acc_rd && paddr == REG_DATA)  rptr <= rptr + 1'b1;
    end
  end

  assign prdata = data_sel_q ? ram_q : rd_hold;

  a_r4_rptr_step: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && paddr == REG_DATA) |=> (rptr == $past(rptr) + 1'b1));

  a_r10_rptr_load: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && paddr == REG_RPTR) |=> (rptr == $past(pwdata[ADDR_W-1:0])));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int ID_W   = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic [DATA_W-1:0] tr_data,
  input  logic [ID_W-1:0]   tr_id,
  input  logic              trig_in,
  output logic              trig_out,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [2:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);
  logic              cfg_en, cfg_bypass;
  logic [CNT_W-1:0]  cfg_trigcnt;
  logic              wptr_ld, stat_clr, fmt_restart;
  logic [ADDR_W-1:0] wptr_val, wptr, rptr;
  logic              wr_en, full, triggered, stopped;
  logic [DATA_W-1:0] wr_data, ram_q;
  logic              ram_re;

  trcb_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst),
    .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_data(tr_data), .tr_id(tr_id),
    .trig_in(trig_in), .trig_out(trig_out),
    .cfg_en(cfg_en), .cfg_bypass(cfg_bypass), .cfg_trigcnt(cfg_trigcnt),
    .wptr_ld(wptr_ld), .wptr_val(wptr_val), .stat_clr(stat_clr), .fmt_restart(fmt_restart),
    .wr_en(wr_en), .wptr(wptr), .wr_data(wr_data),
    .full(full), .triggered(triggered), .stopped(stopped)
  );

  trcb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .st_full(full), .st_trig(triggered), .st_stop(stopped),
    .wptr(wptr), .ram_q(ram_q), .ram_re(ram_re), .rptr(rptr),
    .cfg_en(cfg_en), .cfg_bypass(cfg_bypass), .cfg_trigcnt(cfg_trigcnt),
    .wptr_ld(wptr_ld), .wptr_val(wptr_val), .stat_clr(stat_clr), .fmt_restart(fmt_restart)
  );

  trcb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(wr_data),
    .re(ram_re), .raddr(rptr), .rdata(ram_q)
  );

  a_r5_disabled_ready: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !$past(cfg_en)) |-> (tr_ready && !wr_en));
endmodule

// File: tb/tb_trace_capture_buf.sv
module tb_trace_capture_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int IW = 4;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tr_valid = 1'b0;
  logic tr_ready;
  logic [DW-1:0] tr_data = '0;
  logic [IW-1:0] tr_id = '0;
  logic trig_in = 1'b0;
  logic trig_out;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [2:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;

  int checks = 0;
  int errors = 0;
  int trig_pulses = 0;
  int ready_low = 0;
  logic [DW-1:0] rd;

  trace_capture_buf #(.DATA_W(DW), .ADDR_W(AW), .ID_W(IW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_ready(tr_ready),
    .tr_data(tr_data), .tr_id(tr_id), .trig_in(trig_in), .trig_out(trig_out),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && trig_out) trig_pulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // offer one word; waits while ready is low
  task automatic send(input logic [DW-1:0] d, input logic [IW-1:0] id);
    @(negedge clk); tr_valid = 1; tr_data = d; tr_id = id;
    while (!tr_ready) begin
      ready_low++;
      @(negedge clk);
    end
    @(negedge clk);
    if (!tr_ready) ready_low++;
    tr_valid = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] exp_mem [DEPTH];
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 ready", 32'(tr_ready), 1);
    for (int i = 0; i < 6; i++) begin
      if (i != 4) begin
        reg_rd(3'(i), rd);
        chk($sformatf("R1 reg%0d", i), 32'(rd), 0);
      end
    end

    // R5 disabled: dropped, ready high
    for (int i = 0; i < 3; i++) send(16'h1000 + 16'(i), 0);
    chk("R5 ready while disabled", 32'(tr_ready), 1);
    reg_rd(3'd2, rd); chk("R5 wptr unchanged", 32'(rd), 0);

    // R6 bypass: 10 words into 8 entries
    reg_wr(3'd0, 16'h3);
    reg_rd(3'd0, rd); chk("R3 ctrl readback", 32'(rd), 3);
    ready_low = 0;
    for (int i = 0; i < 10; i++) begin
      send(16'hA000 + 16'(i * 3), 4'(i));
      exp_mem[i % DEPTH] = 16'hA000 + 16'(i * 3);
    end
    chk("R6 ready never low", 32'(ready_low), 0);
    reg_rd(3'd2, rd); chk("R2 wptr wrapped", 32'(rd), 10 % DEPTH);
    reg_rd(3'd1, rd); chk("R2 full set", 32'(rd), 1);
    // R10 rptr load + R4 drain with wrap
    reg_wr(3'd3, 16'(DEPTH - 1));
    for (int k = 0; k < DEPTH; k++) begin
      reg_rd(3'd4, rd);
      chk($sformatf("R4 data idx%0d", (DEPTH - 1 + k) % DEPTH), 32'(rd),
          32'(exp_mem[(DEPTH - 1 + k) % DEPTH]));
    end
    reg_rd(3'd3, rd); chk("R4 rptr after wrap", 32'(rd), DEPTH - 1);
    reg_wr(3'd1, 0);
    reg_rd(3'd1, rd); chk("R3 status cleared", 32'(rd), 0);

    // R7 formatted mode
    reg_wr(3'd0, 16'h1);
    reg_wr(3'd2, 16'h0);
    ready_low = 0;
    send(16'h0011, 4'd5);
    send(16'h0022, 4'd5);
    send(16'h0033, 4'd9);
    send(16'h0044, 4'd5);
    repeat (2) @(negedge clk);
    chk("R7 ready low cycles", 32'(ready_low), 3);
    reg_rd(3'd2, rd); chk("R7 wptr", 32'(rd), 7);
    reg_wr(3'd3, 16'h0);
    begin
      logic [DW-1:0] ex [7];
      ex[0] = 16'h8005; ex[1] = 16'h0011; ex[2] = 16'h0022; ex[3] = 16'h8009;
      ex[4] = 16'h0033; ex[5] = 16'h8005; ex[6] = 16'h0044;
      for (int k = 0; k < 7; k++) begin
        reg_rd(3'd4, rd);
        chk($sformatf("R7 word%0d", k), 32'(rd), 32'(ex[k]));
      end
    end

    // R8 trigger with count 3, bypass
    reg_wr(3'd0, 16'h3);
    reg_wr(3'd2, 16'h0);
    reg_wr(3'd1, 0);
    reg_wr(3'd5, 16'd3);
    trig_pulses = 0;
    send(16'h0101, 0);
    send(16'h0202, 0);
    pulse_trig();
    ready_low = 0;
    for (int i = 0; i < 6; i++) send(16'h0300 + 16'(i), 0);
    repeat (3) @(negedge clk);
    reg_rd(3'd2, rd); chk("R8 wptr after count 3", 32'(rd), 5);
    reg_rd(3'd1, rd); chk("R8 status trig+stop", 32'(rd), 6);
    chk("R8 ready while stopped", 32'(ready_low), 0);
    chk("R9 single trig_out pulse", 32'(trig_pulses), 1);
    reg_wr(3'd3, 16'd4);
    reg_rd(3'd4, rd); chk("R8 last stored word", 32'(rd), 32'h0302);

    // R8 trigger count 0
    reg_wr(3'd1, 0);
    reg_wr(3'd5, 16'd0);
    trig_pulses = 0;
    pulse_trig();
    for (int i = 0; i < 3; i++) send(16'h0400 + 16'(i), 0);
    repeat (2) @(negedge clk);
    reg_rd(3'd2, rd); chk("R8 count0 wptr unchanged", 32'(rd), 5);
    chk("R9 count0 pulse", 32'(trig_pulses), 1);

    // R10 wptr load then store lands there
    reg_wr(3'd1, 0);
    reg_wr(3'd2, 16'd6);
    send(16'hBEEF, 0);
    reg_rd(3'd2, rd); chk("R10 wptr after load+write", 32'(rd), 7);
    reg_wr(3'd3, 16'd6);
    reg_rd(3'd4, rd); chk("R10 data at loaded wptr", 32'(rd), 32'hBEEF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule